// File: doc/BRIEF.md
# Inverter Safe-State Gate Controller

This block sits between the six PWM gate commands of a three-phase inverter bridge and the gate drive outputs. In normal operation it passes each phase's high/low command to the gates and adds a programmable dead time whenever a phase changes state. It never lets the high-side and low-side gates of one phase conduct together.

When a switch-level fault or a supervisor request arrives, the block overrides PWM and shorts the motor windings actively. It turns on all three switches of one side and holds the other side off, which stops uncontrolled regenerative braking torque. The side is chosen from the failure mode. A low-side switch stuck open forces the high-side short. All other local faults force the low-side short. A supervisor request names the side it wants, and conflicts are resolved by a fixed priority.

Every fault source latches its own sticky status bit and pulls an active-low interrupt. The safe state stays in force until a clear strobe arrives while no fault input is active. After that, PWM resumes only after one dead-time interval.

Top module: `inv_safe_gate`

## Requirements
- R1: While reset is asserted and right after it, all gates are off, the status word is zero and `irq_n` is high.
- R2: A change of a phase's command {hi,lo} is first sampled at edge E0. From the output after E0 up to and including the output after edge E0+D (D = `dead_cyc`), both gates of that phase are off. After edge E0+D+1 the new command is on the gates. A phase whose command does not change keeps its gates steady.
- R3: The command 10 turns the high gate on and 01 turns the low gate on. The commands 00 and 11 leave both gates of the phase off. A high and a low gate of the same phase are never on together.
- R4: A desaturation, over-current, over-temperature, under-voltage or high-side-open fault input is sampled at edge E. After E its status bit is set, all low gates are on and all high gates are off. There is no extra latency.
- R5: A low-side-open input forces the high-side short: all high gates on and all low gates off. This takes precedence over every other request, from the edge that samples it.
- R6: A supervisor request (`sup_req` with side `sup_hi`, 1 meaning high-side) first sampled at edge E0 changes nothing at E0 or E0+1. After E0+2 its status bit is set and the named side is shorted. While `sup_req` is held, the gates are never left unforced for more than SUP_LIM cycles.
- R7: When both short sides are requested, the low-side short is chosen unless the low-side-open bit is set.
- R8: Status bit map: 0 desaturation, 1 over-current, 2 over-temperature, 3 under-voltage, 4 high-side open, 5 low-side open, 6 supervisor low-side request, 7 supervisor high-side request. A set bit stays set until `clr` is high.
- R9: `irq_n` is low in every cycle in which any status bit is set.
- R10: `clr` clears every status bit whose input is inactive in that cycle. A bit whose input is still active stays set, and so does the short.
- R11: The last status bit is cleared at edge C. The gates follow the PWM commands again after edge C+D, and are all off after edges C through C+D-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_hi | input | PHASES | High-side PWM commands, one per phase |
| pwm_lo | input | PHASES | Low-side PWM commands, one per phase |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| flt_desat | input | 1 | Desaturation / short-circuit fault |
| flt_ocur | input | 1 | Over-current fault |
| flt_otemp | input | 1 | Over-temperature fault |
| flt_uvolt | input | 1 | Under-voltage fault |
| hs_open | input | 1 | A high-side switch has failed open |
| ls_open | input | 1 | A low-side switch has failed open |
| sup_req | input | 1 | Supervisor safe-state request (asynchronous) |
| sup_hi | input | 1 | Side the supervisor asks for: 1 high, 0 low |
| clr | input | 1 | Clear strobe for sticky status bits |
| gate_hi | output | PHASES | High-side gate drives |
| gate_lo | output | PHASES | Low-side gate drives |
| irq_n | output | 1 | Active-low interrupt, low while any status bit is set |
| status | output | 8 | Sticky fault status word |

## Verification
The dead-time path is swept over every pair of old and new phase commands, on each phase, for dead times 0 to 3. This separates true transitions, which must open a gap of exactly D+1 outputs, from unchanged commands and the two off encodings, which must leave the gates unchanged. Each fault source is then pulsed alone. That shows the side chosen per source, the one-edge reaction and the sticky bit, and the clear-then-resume sequence shows the exit gap. Combined requests test the priority: a supervisor high-side request on top of a desaturation fault, then a low-side-open fault added on top. A clear issued while a fault input is still held shows that the short is kept.

// File: rtl/inv_safe_gate.sv
module inv_safe_gate #(
  parameter int PHASES  = 3,
  parameter int DT_W    = 4,
  parameter int SUP_LIM = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] pwm_hi,
  input  logic [PHASES-1:0] pwm_lo,
  input  logic [DT_W-1:0]   dead_cyc,
  input  logic              flt_desat,
  input  logic              flt_ocur,
  input  logic              flt_otemp,
  input  logic              flt_uvolt,
  input  logic              hs_open,
  input  logic              ls_open,
  input  logic              sup_req,
  input  logic              sup_hi,
  input  logic              clr,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              irq_n,
  output logic [7:0]        status
);
  localparam int CW = $clog2(SUP_LIM + 2);

  logic [1:0] sup_q, side_q;
  logic [7:0] raw, lat_q, lat_d;
  logic       any_d, want_lo, force_hi_d, force_lo_d;
  logic       force_hi_q, force_lo_q;
  logic [PHASES-1:0] norm_hi, norm_lo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sup_q  <= '0;
      side_q <= '0;
    end else begin
      sup_q  <= {sup_q[0], sup_req};
      side_q <= {side_q[0], sup_hi};
    end

  assign raw = {sup_q[1] & side_q[1], sup_q[1] & ~side_q[1], ls_open, hs_open,
                flt_uvolt, flt_otemp, flt_ocur, flt_desat};
  assign lat_d      = raw | (lat_q & {8{~clr}});
  assign any_d      = |lat_d;
  assign want_lo    = |{lat_d[6], lat_d[4:0]};
  assign force_hi_d = lat_d[5] | (lat_d[7] & ~want_lo);
  assign force_lo_d = want_lo & ~lat_d[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) force_hi_q <= 1'b0;
    else        force_hi_q <= force_hi_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) force_lo_q <= 1'b0;
    else        force_lo_q <= force_lo_d;

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    logic [1:0]      cmd, cmd_q;
    logic [DT_W-1:0] cnt;
    assign cmd = {pwm_hi[i], pwm_lo[i]};
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmd_q <= '0;
        cnt   <= '0;
      end else begin
        cmd_q <= cmd;
        if (any_d || cmd != cmd_q) cnt <= dead_cyc;
        else if (cnt != '0)        cnt <= cnt - 1'b1;
      end
    assign norm_hi[i] = (cnt == '0) && (cmd == cmd_q) && (cmd_q == 2'b10);
    assign norm_lo[i] = (cnt == '0) && (cmd == cmd_q) && (cmd_q == 2'b01);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gate_hi <= '0;
    else        gate_hi <= {PHASES{force_hi_d}} | ({PHASES{~force_lo_d}} & norm_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gate_lo <= '0;
    else        gate_lo <= {PHASES{force_lo_d}} | ({PHASES{~force_hi_d}} & norm_lo);

  assign status = lat_q;
  assign irq_n  = ~|lat_q;

  logic [CW-1:0] sup_wait;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sup_wait <= '0;
    else if (sup_req && !(force_hi_q || force_lo_q)) begin
      if (sup_wait != CW'(SUP_LIM + 1)) sup_wait <= sup_wait + 1'b1;
    end else sup_wait <= '0;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R3
  AST_DESAT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    flt_desat |=> (!irq_n && ((&gate_lo && gate_hi == '0) || (&gate_hi && gate_lo == '0)))); // R4
  AST_LO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[5] && |{status[6], status[4:0]}) |-> (&gate_lo && gate_hi == '0)); // R7
  AST_HS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> (&gate_hi && gate_lo == '0)); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status))); // R8
  AST_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_ocur) |=> !irq_n); // R9
  AST_SUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sup_wait <= CW'(SUP_LIM)); // R6
endmodule

// File: tb/sim_inv_safe_gate.sv
module sim_inv_safe_gate;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [2:0] pwm_hi = 0, pwm_lo = 0;
  logic [3:0] dead_cyc = 0;
  logic [5:0] lf = 0;
  logic sup_req = 0, sup_hi = 0, clr = 0;
  logic [2:0] gate_hi, gate_lo;
  logic irq_n;
  logic [7:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  inv_safe_gate #(.PHASES(3), .DT_W(4), .SUP_LIM(16)) u0 (
    .clk, .rst_n, .pwm_hi, .pwm_lo, .dead_cyc,
    .flt_desat(lf[0]), .flt_ocur(lf[1]), .flt_otemp(lf[2]), .flt_uvolt(lf[3]),
    .hs_open(lf[4]), .ls_open(lf[5]), .sup_req, .sup_hi, .clr,
    .gate_hi, .gate_lo, .irq_n, .status);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_gates(string req, logic [2:0] eh, logic [2:0] el);
    chk(req, {gate_hi, gate_lo}, {eh, el});
  endtask

  task automatic chk_resume(string req);
    int d = int'(dead_cyc);
    for (int k = 0; k < d; k++) begin
      chk_gates(req, 3'b000, 3'b000);
      tick();
    end
    chk_gates(req, pwm_hi & ~pwm_lo, pwm_lo & ~pwm_hi);
  endtask

  task automatic do_clear;
    clr = 1;
    tick();
    clr = 0;
  endtask

  task automatic one_fault(int idx, bit hi_side);
    lf = 6'(1 << idx);
    tick();
    lf = 0;
    chk("R8 status bit", status, 32'(1 << idx));
    chk("R9 irq", irq_n, 0);
    if (hi_side) chk_gates("R5 high short", 3'b111, 3'b000);
    else         chk_gates("R4 low short", 3'b000, 3'b111);
    tick(); tick(); tick();
    chk("R8 sticky", status, 32'(1 << idx));
    do_clear();
    chk("R10 cleared", status, 0);
    chk("R9 irq released", irq_n, 1);
    chk_resume("R11 resume");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_gates("R1 reset gates", 3'b000, 3'b000);
    chk("R1 reset status", status, 0);
    chk("R1 reset irq", irq_n, 1);
    tick();
    rst_n = 1;
    tick();
    chk("R1 after reset", {gate_hi, gate_lo, status, 7'd0, irq_n}, {6'd0, 8'd0, 8'd1});

    // R2 / R3 sweep
    for (int d = 0; d < 4; d++) begin
      dead_cyc = 4'(d);
      for (int p = 0; p < 3; p++) begin
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            logic [2:0] ah, al, bh, bl;
            ah = (a == 2) ? 3'(1 << p) : 3'b0;
            al = (a == 1) ? 3'(1 << p) : 3'b0;
            bh = (b == 2) ? 3'(1 << p) : 3'b0;
            bl = (b == 1) ? 3'(1 << p) : 3'b0;
            pwm_hi = 3'(a[1] << p);
            pwm_lo = 3'(a[0] << p);
            for (int w = 0; w < d + 3; w++) tick();
            chk_gates("R3 steady map", ah, al);
            pwm_hi = 3'(b[1] << p);
            pwm_lo = 3'(b[0] << p);
            for (int k = 0; k <= d; k++) begin
              tick();
              if (a != b) chk_gates("R2 dead gap", 3'b000, 3'b000);
              else        chk_gates("R2 unchanged", ah, al);
            end
            tick();
            chk_gates("R2 new state", bh, bl);
          end
        end
      end
    end

    // R4 / R5 per source
    dead_cyc = 2;
    pwm_hi = 3'b101;
    pwm_lo = 3'b010;
    for (int w = 0; w < 5; w++) tick();
    chk_gates("R3 pwm pattern", 3'b101, 3'b010);
    for (int i = 0; i < 5; i++) one_fault(i, 1'b0);
    one_fault(5, 1'b1);

    // R6 supervisor, both sides
    for (int s = 0; s < 2; s++) begin
      sup_req = 1;
      sup_hi = s[0];
      tick();
      chk("R6 no early act", status, 0);
      tick();
      chk_gates("R6 still pwm", 3'b101, 3'b010);
      tick();
      chk("R6 status", status, s ? 32'h80 : 32'h40);
      if (s) chk_gates("R6 high short", 3'b111, 3'b000);
      else   chk_gates("R6 low short", 3'b000, 3'b111);
      sup_req = 0;
      tick(); tick(); tick();
      do_clear();
      chk("R10 sup cleared", status, 0);
      chk_resume("R11 sup resume");
    end

    // R7 priority
    lf = 6'b000001;
    sup_req = 1;
    sup_hi = 1;
    tick();
    lf = 0;
    chk_gates("R4 desat first", 3'b000, 3'b111);
    tick(); tick();
    chk("R7 both latched", status, 32'h81);
    chk_gates("R7 low wins", 3'b000, 3'b111);
    lf = 6'b100000;
    tick();
    lf = 0;
    chk("R7 ls open latched", status, 32'hA1);
    chk_gates("R7 ls open flips to high", 3'b111, 3'b000);
    sup_req = 0;
    tick(); tick(); tick();
    do_clear();
    chk("R10 all cleared", status, 0);
    chk_resume("R11 resume after priority");

    // R10 clear while active
    lf = 6'b000010;
    tick();
    do_clear();
    chk("R10 active bit kept", status, 32'h02);
    chk("R9 irq kept", irq_n, 0);
    chk_gates("R10 short kept", 3'b000, 3'b111);
    lf = 0;
    tick();
    chk("R8 still set", status, 32'h02);
    do_clear();
    chk("R10 released", status, 0);
    chk_resume("R11 final resume");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule